// File: doc/BRIEF.md
# Command Stream Packet Parser

This block sits behind a command fetcher and splits a stream of 32-bit command words into work for two consumers. Words arrive on a valid/ready input. The parser reads the top two bits of each header word to pick one of four packet classes. It works out how many payload words follow, then routes each payload word to one of two channels. The register channel carries a register index and a data word. The command channel carries an opcode, a predicate flag, first and last markers, and the data word.

The block never stores a payload word. While a payload word is due on a channel, the input ready follows that channel's ready, so backpressure from a consumer passes straight back to the source. Header words are always accepted at once. No-op headers disappear without a trace. The block holds only the state of the packet in progress: its class, the words still to come, the current register index, and the command tags.

Top module: `cmdpkt_parser`

## Requirements
- R1: Header bits 31:30 select the packet class: 0 is a register-write run, 1 is a two-register write, 2 is a no-op, and 3 is a command.
- R2: A register-write run carries (header bits 29:16) + 1 data words, so from 1 to 16384. The word after the last data word is parsed as a header.
- R3: In a register-write run with header bit 15 clear, data word i (counting from 0) writes register (header bits 14:0) + i, modulo 2^15.
- R4: In a register-write run with header bit 15 set, every data word writes register header bits 14:0.
- R5: A two-register packet is the header plus exactly two data words. The first data word writes the index in header bits 10:0, zero-extended. The second writes the index in header bits 21:11. Bits 29:22 are ignored.
- R6: A no-op packet is the header word alone. It is consumed and produces no transfer on either output channel.
- R7: A command packet carries (header bits 29:16) + 1 payload beats. Each beat presents the data word with the opcode from header bits 14:8 and the predicate from header bit 0.
- R8: The first beat of a command has cmd_first = 1. The beat that uses up the count has cmd_last = 1. A one-beat command has both set.
- R9: While a payload word is due, in_ready equals the ready of the addressed channel. Every word is delivered exactly once and in order. The channel fields stay stable while valid is held without ready.
- R10: A synchronous active-high reset, even in the middle of a packet, returns the parser to expecting a header. Both output valids are then low.
- R11: While a header is expected, in_ready is high and neither output channel is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Command stream word |
| reg_valid | output | 1 | Register write valid |
| reg_ready | input | 1 | Register channel ready |
| reg_index | output | 15 | Register index |
| reg_data | output | 32 | Register data |
| cmd_valid | output | 1 | Command beat valid |
| cmd_ready | input | 1 | Command channel ready |
| cmd_opcode | output | 7 | Command opcode |
| cmd_pred | output | 1 | Command predicate flag |
| cmd_first | output | 1 | First beat of a command |
| cmd_last | output | 1 | Last beat of a command |
| cmd_data | output | 32 | Command payload word |

## Verification
The bench builds the block with the field widths from the package, unchanged: a 14-bit count, a 15-bit run index, 11-bit pair indices and a 7-bit opcode. At these widths a run whose count field is all ones (16384 data words) fits in a short run at full throughput. A run that starts two below the top of the index space reaches the wrap to zero. Random input gaps and independent channel readies then test that each word is delivered once, across every class change and through a reset in the middle of a packet.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;

    localparam int WORD_W     = 32;
    localparam int IDX_W      = 15;
    localparam int CNT_W      = 14;
    localparam int OP_W       = 7;
    localparam int PAIR_IDX_W = 11;

    localparam int CLS_LSB    = 30;
    localparam int CNT_LSB    = 16;
    localparam int SAME_BIT   = 15;
    localparam int OP_LSB     = 8;
    localparam int PAIR_B_LSB = PAIR_IDX_W;
    localparam int PRED_BIT   = 0;
    localparam int LEN_W      = CNT_W + 1;

    typedef enum logic [1:0] {
        CLS_RUN  = 2'd0,
        CLS_PAIR = 2'd1,
        CLS_NOP  = 2'd2,
        CLS_CMD  = 2'd3
    } pkt_class_e;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_RUN,
        ST_PAIR,
        ST_CMD
    } parse_st_e;

    typedef struct packed {
        pkt_class_e            cls;
        logic [LEN_W-1:0]      len;
        logic [IDX_W-1:0]      base;
        logic                  same;
        logic [PAIR_IDX_W-1:0] idx_a;
        logic [PAIR_IDX_W-1:0] idx_b;
        logic [OP_W-1:0]       op;
        logic                  pred;
    } hdr_fields_t;

endpackage

// File: rtl/cmdpkt_hdr_decode.sv
module cmdpkt_hdr_decode
    import cmdpkt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_fields_t       fields
);

    always_comb begin
        fields.cls   = pkt_class_e'(word[CLS_LSB +: 2]);
        fields.len   = {1'b0, word[CNT_LSB +: CNT_W]} + LEN_W'(1);
        fields.base  = word[IDX_W-1:0];
        fields.same  = word[SAME_BIT];
        fields.idx_a = word[PAIR_IDX_W-1:0];
        fields.idx_b = word[PAIR_B_LSB +: PAIR_IDX_W];
        fields.op    = word[OP_LSB +: OP_W];
        fields.pred  = word[PRED_BIT];
    end

endmodule

// File: rtl/cmdpkt_core.sv
module cmdpkt_core
    import cmdpkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  hdr_fields_t      hdr,
    output logic             reg_valid,
    input  logic             reg_ready,
    output logic [IDX_W-1:0] reg_index,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [OP_W-1:0]  cmd_opcode,
    output logic             cmd_pred,
    output logic             cmd_first,
    output logic             cmd_last
);

    localparam int PAD_W = IDX_W - PAIR_IDX_W;

    typedef struct packed {
        parse_st_e             st;
        logic [LEN_W-1:0]      remain;
        logic [IDX_W-1:0]      idx;
        logic [PAIR_IDX_W-1:0] idx_b;
        logic                  same;
        logic [OP_W-1:0]       op;
        logic                  pred;
        logic                  first;
    } state_t;

    localparam state_t STATE_RST = '{
        st:     ST_HDR,
        remain: '0,
        idx:    '0,
        idx_b:  '0,
        same:   1'b0,
        op:     '0,
        pred:   1'b0,
        first:  1'b0
    };

    state_t s_d, s_q;
    logic   xfer_reg, xfer_cmd;

    always_comb begin
        s_d       = s_q;
        in_ready  = 1'b0;
        reg_valid = 1'b0;
        cmd_valid = 1'b0;
        xfer_reg  = 1'b0;
        xfer_cmd  = 1'b0;
        unique case (s_q.st)
            ST_HDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    unique case (hdr.cls)
                        CLS_RUN: begin
                            s_d.st     = ST_RUN;
                            s_d.remain = hdr.len;
                            s_d.idx    = hdr.base;
                            s_d.same   = hdr.same;
                        end
                        CLS_PAIR: begin
                            s_d.st     = ST_PAIR;
                            s_d.remain = LEN_W'(2);
                            s_d.idx    = {{PAD_W{1'b0}}, hdr.idx_a};
                            s_d.idx_b  = hdr.idx_b;
                        end
                        CLS_CMD: begin
                            s_d.st     = ST_CMD;
                            s_d.remain = hdr.len;
                            s_d.op     = hdr.op;
                            s_d.pred   = hdr.pred;
                            s_d.first  = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_RUN, ST_PAIR: begin
                reg_valid = in_valid;
                in_ready  = reg_ready;
                xfer_reg  = in_valid && reg_ready;
                if (xfer_reg) begin
                    s_d.remain = s_q.remain - LEN_W'(1);
                    if (s_q.st == ST_PAIR) begin
                        s_d.idx = {{PAD_W{1'b0}}, s_q.idx_b};
                    end else if (!s_q.same) begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                    if (s_q.remain == LEN_W'(1)) begin
                        s_d.st = ST_HDR;
                    end
                end
            end
            ST_CMD: begin
                cmd_valid = in_valid;
                in_ready  = cmd_ready;
                xfer_cmd  = in_valid && cmd_ready;
                if (xfer_cmd) begin
                    s_d.remain = s_q.remain - LEN_W'(1);
                    s_d.first  = 1'b0;
                    if (s_q.remain == LEN_W'(1)) begin
                        s_d.st = ST_HDR;
                    end
                end
            end
            default: s_d = STATE_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= STATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_index  = s_q.idx;
    assign cmd_opcode = s_q.op;
    assign cmd_pred   = s_q.pred;
    assign cmd_first  = s_q.first;
    assign cmd_last   = (s_q.remain == LEN_W'(1));

    // R6: a no-op header leaves the parser expecting a header
    p_nop_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_HDR && in_valid && hdr.cls == CLS_NOP) |=> (s_q.st == ST_HDR));

    // R5: a two-register header always opens a two-word payload
    p_pair_len_r5: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_HDR && in_valid && hdr.cls == CLS_PAIR) |=> (s_q.remain == LEN_W'(2)));

    // R4: repeat mode keeps the register index between beats
    p_same_idx_r4: assert property (@(posedge clk) disable iff (rst)
        (xfer_reg && s_q.st == ST_RUN && s_q.same && s_q.remain != LEN_W'(1))
        |=> (reg_index == $past(reg_index)));

    // R3: stepping mode advances the index by one, wrapping
    p_step_idx_r3: assert property (@(posedge clk) disable iff (rst)
        (xfer_reg && s_q.st == ST_RUN && !s_q.same && s_q.remain != LEN_W'(1))
        |=> (reg_index == IDX_W'($past(reg_index) + IDX_W'(1))));

    // R8: a command header opens a beat marked first
    p_first_beat_r8: assert property (@(posedge clk) disable iff (rst)
        (s_q.st == ST_HDR && in_valid && hdr.cls == CLS_CMD) |=> cmd_first);

    // R8: the last beat hands control back to header parsing
    p_last_beat_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_last) |=> (s_q.st == ST_HDR));

    // R9: a stalled register write keeps its index and progress
    p_reg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_ready) |=> ($stable(reg_index) && $stable(s_q.remain)));

    // R9: a stalled command beat keeps its tags
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready)
        |=> ($stable(cmd_opcode) && $stable(cmd_pred) && $stable(cmd_first) && $stable(cmd_last)));

endmodule

// File: rtl/cmdpkt_parser.sv
module cmdpkt_parser
    import cmdpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              reg_valid,
    input  logic              reg_ready,
    output logic [IDX_W-1:0]  reg_index,
    output logic [WORD_W-1:0] reg_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [OP_W-1:0]   cmd_opcode,
    output logic              cmd_pred,
    output logic              cmd_first,
    output logic              cmd_last,
    output logic [WORD_W-1:0] cmd_data
);

    hdr_fields_t hdr;

    cmdpkt_hdr_decode u_decode (
        .word   (in_data),
        .fields (hdr)
    );

    cmdpkt_core u_core (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .hdr        (hdr),
        .reg_valid  (reg_valid),
        .reg_ready  (reg_ready),
        .reg_index  (reg_index),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_opcode (cmd_opcode),
        .cmd_pred   (cmd_pred),
        .cmd_first  (cmd_first),
        .cmd_last   (cmd_last)
    );

    assign reg_data = in_data;
    assign cmd_data = in_data;

    // R11: outputs are never valid on both channels at once
    p_one_channel_r11: assert property (@(posedge clk) disable iff (rst)
        !(reg_valid && cmd_valid));

endmodule

// File: tb/cmdpkt_parser_test.sv
`timescale 1ns/1ps
module cmdpkt_parser_test;
    import cmdpkt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [WORD_W-1:0] in_data = '0;
    logic              reg_valid;
    logic              reg_ready = 1'b0;
    logic [IDX_W-1:0]  reg_index;
    logic [WORD_W-1:0] reg_data;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [OP_W-1:0]   cmd_opcode;
    logic              cmd_pred;
    logic              cmd_first;
    logic              cmd_last;
    logic [WORD_W-1:0] cmd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdpkt_parser uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_index(reg_index), .reg_data(reg_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_pred(cmd_pred),
        .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_data(cmd_data)
    );

    typedef struct {
        int unsigned idx;
        logic [31:0] data;
        string       tag;
    } reg_exp_t;

    typedef struct {
        int unsigned op;
        bit          pred;
        bit          first;
        bit          last;
        logic [31:0] data;
        string       tag;
    } cmd_exp_t;

    logic [31:0] in_q[$];
    reg_exp_t    reg_q[$];
    cmd_exp_t    cmd_q[$];
    int          tests = 0;
    int          fails = 0;
    int          reg_xfers = 0;
    int          cmd_xfers = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic send_run(int unsigned base, int n, bit same, string tag);
        in_q.push_back({2'b00, 14'(n - 1), same, 15'(base)});
        for (int i = 0; i < n; i++) begin
            logic [31:0] d;
            d = $urandom;
            in_q.push_back(d);
            reg_q.push_back('{idx: same ? base : ((base + i) & 32'h7FFF), data: d, tag: tag});
        end
    endtask

    task automatic send_pair(int unsigned a, int unsigned b, string tag);
        logic [31:0] d0, d1;
        d0 = $urandom;
        d1 = $urandom;
        in_q.push_back({2'b01, 8'hA5, 11'(b), 11'(a)});
        in_q.push_back(d0);
        in_q.push_back(d1);
        reg_q.push_back('{idx: a & 32'h7FF, data: d0, tag: tag});
        reg_q.push_back('{idx: b & 32'h7FF, data: d1, tag: tag});
    endtask

    task automatic send_nop();
        in_q.push_back({2'b10, 30'($urandom)});
    endtask

    task automatic send_cmd(int unsigned op, int n, bit pred, string tag);
        in_q.push_back({2'b11, 14'(n - 1), 1'b0, 7'(op), 7'h2A, pred});
        for (int i = 0; i < n; i++) begin
            logic [31:0] d;
            d = $urandom;
            in_q.push_back(d);
            cmd_q.push_back('{op: op & 32'h7F, pred: pred, first: (i == 0), last: (i == n - 1),
                              data: d, tag: tag});
        end
    endtask

    task automatic sample_cycle();
        check(!(reg_valid && cmd_valid), "R11", "both channels valid", {reg_valid, cmd_valid}, 0);
        if (reg_valid && reg_ready) begin
            reg_xfers++;
            if (reg_q.size() == 0) begin
                check(0, "R6", "unexpected register write", reg_index, 0);
            end else begin
                reg_exp_t e;
                e = reg_q.pop_front();
                check(reg_index == IDX_W'(e.idx), e.tag, "reg_index", reg_index, e.idx);
                check(reg_data == e.data, e.tag, "reg_data", reg_data, e.data);
            end
        end
        if (cmd_valid && cmd_ready) begin
            cmd_xfers++;
            if (cmd_q.size() == 0) begin
                check(0, "R6", "unexpected command beat", cmd_data, 0);
            end else begin
                cmd_exp_t e;
                e = cmd_q.pop_front();
                check(cmd_opcode == OP_W'(e.op), e.tag, "cmd_opcode", cmd_opcode, e.op);
                check(cmd_pred == e.pred, e.tag, "cmd_pred", cmd_pred, e.pred);
                check(cmd_first == e.first, "R8", "cmd_first", cmd_first, e.first);
                check(cmd_last == e.last, "R8", "cmd_last", cmd_last, e.last);
                check(cmd_data == e.data, e.tag, "cmd_data", cmd_data, e.data);
            end
        end
        if (in_valid && in_ready) begin
            void'(in_q.pop_front());
        end
    endtask

    task automatic run_stream(int pct);
        while (in_q.size() > 0) begin
            @(negedge clk);
            in_valid  = (in_q.size() > 0) && (pct == 100 || $urandom_range(99) < 80);
            in_data   = (in_q.size() > 0) ? in_q[0] : $urandom;
            reg_ready = ($urandom_range(99) < pct);
            cmd_ready = ($urandom_range(99) < pct);
            #(CLK_PERIOD/2 - 1);
            sample_cycle();
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_idle(string tag);
        @(negedge clk);
        in_valid = 1'b0;
        #(CLK_PERIOD/2 - 1);
        check(reg_valid == 1'b0, tag, "reg_valid idle", reg_valid, 0);
        check(cmd_valid == 1'b0, tag, "cmd_valid idle", cmd_valid, 0);
        check(in_ready == 1'b1, tag, "in_ready idle", in_ready, 1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int rx, cx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_idle("R10");

        // R2 R3: stepping run
        send_run(32'h100, 3, 1'b0, "R3");
        run_stream(100);
        // R4: repeat run under backpressure
        send_run(32'h20, 4, 1'b1, "R4");
        run_stream(50);
        // R5: two-register write
        send_pair(32'h7FF, 32'h123, "R5");
        run_stream(60);

        // R6: no-ops only, nothing may appear
        rx = reg_xfers;
        cx = cmd_xfers;
        send_nop();
        send_nop();
        send_nop();
        run_stream(100);
        check(reg_xfers == rx && cmd_xfers == cx, "R6", "transfers after no-ops",
              (reg_xfers - rx) + (cmd_xfers - cx), 0);
        check_idle("R11");

        // R7 R8: multi-beat and single-beat commands
        send_cmd(32'h64, 4, 1'b0, "R7");
        send_cmd(32'h3C, 1, 1'b1, "R7");
        run_stream(70);
        // R3: index wrap at the top of the space
        send_run(32'h7FFE, 4, 1'b0, "R3");
        run_stream(100);

        // R1 R9: mixed classes, random gaps and stalls
        for (int k = 0; k < 40; k++) begin
            int sel;
            sel = $urandom_range(3);
            case (sel)
                0: send_run($urandom_range(32'h7FFF), $urandom_range(6, 1), 1'($urandom), "R1");
                1: send_pair($urandom_range(32'h7FF), $urandom_range(32'h7FF), "R1");
                2: send_nop();
                default: send_cmd($urandom_range(127), $urandom_range(6, 1), 1'($urandom), "R9");
            endcase
        end
        run_stream(40);

        // R2: longest run the count field allows
        send_run(32'h10, 16384, 1'b1, "R2");
        run_stream(100);

        // R10: reset in the middle of a run, then a command must parse
        in_q.push_back({2'b00, 14'd4, 1'b0, 15'h40});
        for (int i = 0; i < 2; i++) begin
            logic [31:0] d;
            d = $urandom;
            in_q.push_back(d);
            reg_q.push_back('{idx: 32'h40 + i, data: d, tag: "R10"});
        end
        run_stream(100);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R10");
        send_cmd(32'h11, 2, 1'b1, "R10");
        run_stream(100);

        check(reg_q.size() == 0, "R2", "register writes outstanding", reg_q.size(), 0);
        check(cmd_q.size() == 0, "R7", "command beats outstanding", cmd_q.size(), 0);
        summary();
        $finish;
    end

endmodule